// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter and Strobe Decoder

This block sits on the system side of an 8-bit processor whose low address byte and data byte share one set of pins. At the start of each machine cycle the processor raises a positive address-strobe pulse while the shared lines carry the low address byte. The block remembers that byte at the moment the pulse ends. It joins that byte with the high byte from the processor's dedicated upper address pins and presents a steady 16-bit address for the whole cycle, including any wait states.

The block also turns the processor's active-low read and write strobes and its I/O-versus-memory status bit into four separate active-low strobes: memory read, memory write, I/O read and I/O write. It decodes the two-bit cycle-status code into four one-hot cycle flags. It steers data in both directions with explicit output enables, so that an outer pad ring or system bus can build the tri-state drivers. When the processor lines float, either because the bus has been granted to another master or because the cycle status reports a halt, every derived strobe is held inactive and neither data direction is driven.

All outputs are registered on the system clock, one cycle after the inputs are sampled. The processor-side signals are assumed to be synchronous to that clock.

Top module: `mbus_demux`

## Requirements
- R1: When the address strobe `ale` is sampled high on one clock edge and low on the next, the value on `cpu_ad_i` at the first of those edges appears on `sys_addr_o[7:0]` one clock after the second edge.
- R2: `sys_addr_o` keeps its value on every cycle that does not follow an `ale` high-to-low transition, whatever `cpu_ad_i` and `hi_addr_i` do in that cycle, including during wait states.
- R3: The value on `hi_addr_i` at the last edge where `ale` is sampled high is captured together with the low byte and appears on `sys_addr_o[15:8]` at the same time.
- R4: The bus is floating when `hlda` is 1 or `status` is 2'b00. Outside that condition, one cycle after sampling, `mem_rd_n` is low exactly when `io_m`=0 and `rd_n`=0. `mem_wr_n` is low exactly when `io_m`=0 and `wr_n`=0. `io_rd_n` is low exactly when `io_m`=1 and `rd_n`=0. `io_wr_n` is low exactly when `io_m`=1 and `wr_n`=0.
- R5: One cycle after the bus is sampled as floating, all four derived strobes are 1, whatever `rd_n`, `wr_n` and `io_m` show.
- R6: One cycle after sampling, exactly one of the cycle flags is 1. `status` 2'b00 gives `cyc_halt`, 2'b01 gives `cyc_write`, 2'b10 gives `cyc_read` and 2'b11 gives `cyc_fetch`.
- R7: A read transfer is sampled when `rd_n`=0, `wr_n`=1, `ale`=0 and the bus is not floating. One cycle later `cpu_ad_oe`=1 and `cpu_ad_o` equals the sampled `sys_data_i`. In any other case `cpu_ad_oe`=0 and `cpu_ad_o` keeps its last value.
- R8: A write transfer is sampled when `wr_n`=0, `rd_n`=1, `ale`=0 and the bus is not floating. One cycle later `sys_data_oe`=1 and `sys_data_o` equals the sampled `cpu_ad_i`. In any other case `sys_data_oe`=0 and `sys_data_o` keeps its last value.
- R9: `cpu_ad_oe` and `sys_data_oe` are never 1 together. Neither is 1 in the cycle after `ale` is sampled high or after `rd_n` and `wr_n` are both sampled low.
- R10: While `rst_n` is low, `sys_addr_o`, `cpu_ad_o` and `sys_data_o` are 0, both enables are 0, all four derived strobes are 1 and all four cycle flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe, high during the address phase |
| cpu_ad_i | input | 8 | Value on the shared address/data pins |
| cpu_ad_o | output | 8 | Read data to drive onto the shared pins |
| cpu_ad_oe | output | 1 | Drive enable for the shared pins |
| hi_addr_i | input | 8 | Processor's upper address byte |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| io_m | input | 1 | 1 for an I/O access, 0 for a memory access |
| status | input | 2 | Cycle-type code |
| hlda | input | 1 | Bus granted to another master |
| sys_addr_o | output | 16 | Demultiplexed address |
| sys_data_i | input | 8 | Read data from the system bus |
| sys_data_o | output | 8 | Write data to the system bus |
| sys_data_oe | output | 1 | Drive enable for the system data bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| cyc_halt | output | 1 | Halt cycle flag |
| cyc_write | output | 1 | Write cycle flag |
| cyc_read | output | 1 | Read cycle flag |
| cyc_fetch | output | 1 | Opcode fetch cycle flag |

## Verification
The bench sets the shared lines to a value other than the address during the data phase and keeps changing it through wait states. A latch that is transparent, or that captures on the wrong edge, would then show the data byte or a moving address. It asserts the read strobe while the bus is granted away and while the status reports a halt. A decoder that ignores the floating condition would pulse a memory or I/O strobe with no real access behind it. It also drives both strobes low at once and holds a strobe low while `ale` is high. Steering logic without those guards would enable both drivers together, or drive read data over the address phase.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        CYC_HALT  = 2'b00,
        CYC_WRITE = 2'b01,
        CYC_READ  = 2'b10,
        CYC_FETCH = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobes_t;

    typedef struct packed {
        logic halt;
        logic write;
        logic read;
        logic fetch;
    } cyc_flags_t;

    localparam strobes_t STROBES_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                          io_rd_n: 1'b1, io_wr_n: 1'b1};

    // Processor pins are released when the bus is granted away or the cycle is a halt
    function automatic logic bus_floating(input logic granted, input logic [1:0] st);
        return granted || (st == CYC_HALT);
    endfunction

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale_i,
    input  logic [LO_W-1:0]      ad_i,
    input  logic [HI_W-1:0]      hi_i,
    output logic [LO_W+HI_W-1:0] addr_o
);
    localparam int ADDR_W = LO_W + HI_W;

    typedef struct packed {
        logic            ale;
        logic [LO_W-1:0] ad;
        logic [HI_W-1:0] hi;
    } sample_t;

    sample_t             smp_d, smp_q;
    logic [ADDR_W-1:0]   addr_d, addr_q;

    always_comb begin
        smp_d.ale = ale_i;
        smp_d.ad  = ad_i;
        smp_d.hi  = hi_i;
        addr_d    = addr_q;
        // Close the latch on the strobe's falling edge, keeping the last address-phase sample
        if (smp_q.ale && !ale_i) begin
            addr_d = {smp_q.hi, smp_q.ad};
        end
    end

    // The input samples are not reset so that an edge spanning reset release is still seen
    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/mbus_strobe_decode.sv
module mbus_strobe_decode
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_n_i,
    input  logic       wr_n_i,
    input  logic       io_m_i,
    input  logic [1:0] status_i,
    input  logic       hlda_i,
    output strobes_t   strobes_o,
    output cyc_flags_t flags_o
);
    typedef struct packed {
        strobes_t   stb;
        cyc_flags_t flg;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d.stb = STROBES_IDLE;
        if (!bus_floating(hlda_i, status_i)) begin
            if (!rd_n_i) begin
                if (io_m_i) dec_d.stb.io_rd_n  = 1'b0;
                else        dec_d.stb.mem_rd_n = 1'b0;
            end
            if (!wr_n_i) begin
                if (io_m_i) dec_d.stb.io_wr_n  = 1'b0;
                else        dec_d.stb.mem_wr_n = 1'b0;
            end
        end

        dec_d.flg = '0;
        unique case (cyc_kind_e'(status_i))
            CYC_HALT:  dec_d.flg.halt  = 1'b1;
            CYC_WRITE: dec_d.flg.write = 1'b1;
            CYC_READ:  dec_d.flg.read  = 1'b1;
            CYC_FETCH: dec_d.flg.fetch = 1'b1;
            default:   dec_d.flg       = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q.stb <= STROBES_IDLE;
            dec_q.flg <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign strobes_o = dec_q.stb;
    assign flags_o   = dec_q.flg;
endmodule

// File: rtl/mbus_data_steer.sv
module mbus_data_steer
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic [1:0]    status_i,
    input  logic          hlda_i,
    input  logic [DW-1:0] cpu_ad_i,
    input  logic [DW-1:0] sys_data_i,
    output logic [DW-1:0] cpu_ad_o,
    output logic          cpu_ad_oe,
    output logic [DW-1:0] sys_data_o,
    output logic          sys_data_oe
);
    typedef struct packed {
        logic [DW-1:0] to_cpu;
        logic          to_cpu_en;
        logic [DW-1:0] to_sys;
        logic          to_sys_en;
    } steer_t;

    steer_t st_d, st_q;
    logic   quiet, rd_go, wr_go;

    always_comb begin
        quiet = ale_i || bus_floating(hlda_i, status_i);
        rd_go = !quiet && !rd_n_i && wr_n_i;
        wr_go = !quiet && !wr_n_i && rd_n_i;

        st_d           = st_q;
        st_d.to_cpu_en = rd_go;
        st_d.to_sys_en = wr_go;
        if (rd_go) st_d.to_cpu = sys_data_i;
        if (wr_go) st_d.to_sys = cpu_ad_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ad_o    = st_q.to_cpu;
    assign cpu_ad_oe   = st_q.to_cpu_en;
    assign sys_data_o  = st_q.to_sys;
    assign sys_data_oe = st_q.to_sys_en;
endmodule

// File: rtl/mbus_demux.sv
module mbus_demux
    import mbus_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [LO_W-1:0]      cpu_ad_i,
    output logic [LO_W-1:0]      cpu_ad_o,
    output logic                 cpu_ad_oe,
    input  logic [HI_W-1:0]      hi_addr_i,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 io_m,
    input  logic [1:0]           status,
    input  logic                 hlda,
    output logic [LO_W+HI_W-1:0] sys_addr_o,
    input  logic [LO_W-1:0]      sys_data_i,
    output logic [LO_W-1:0]      sys_data_o,
    output logic                 sys_data_oe,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 io_rd_n,
    output logic                 io_wr_n,
    output logic                 cyc_halt,
    output logic                 cyc_write,
    output logic                 cyc_read,
    output logic                 cyc_fetch
);
    strobes_t   stb;
    cyc_flags_t flg;

    mbus_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale_i  (ale),
        .ad_i   (cpu_ad_i),
        .hi_i   (hi_addr_i),
        .addr_o (sys_addr_o)
    );

    mbus_strobe_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n_i    (rd_n),
        .wr_n_i    (wr_n),
        .io_m_i    (io_m),
        .status_i  (status),
        .hlda_i    (hlda),
        .strobes_o (stb),
        .flags_o   (flg)
    );

    mbus_data_steer #(.DW(LO_W)) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ale_i       (ale),
        .rd_n_i      (rd_n),
        .wr_n_i      (wr_n),
        .status_i    (status),
        .hlda_i      (hlda),
        .cpu_ad_i    (cpu_ad_i),
        .sys_data_i  (sys_data_i),
        .cpu_ad_o    (cpu_ad_o),
        .cpu_ad_oe   (cpu_ad_oe),
        .sys_data_o  (sys_data_o),
        .sys_data_oe (sys_data_oe)
    );

    assign mem_rd_n  = stb.mem_rd_n;
    assign mem_wr_n  = stb.mem_wr_n;
    assign io_rd_n   = stb.io_rd_n;
    assign io_wr_n   = stb.io_wr_n;
    assign cyc_halt  = flg.halt;
    assign cyc_write = flg.write;
    assign cyc_read  = flg.read;
    assign cyc_fetch = flg.fetch;
endmodule

// File: rtl/mbus_demux_chk.sv
module mbus_demux_chk #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ale,
    input logic [LO_W-1:0]      cpu_ad_i,
    input logic                 cpu_ad_oe,
    input logic [HI_W-1:0]      hi_addr_i,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 io_m,
    input logic [1:0]           status,
    input logic                 hlda,
    input logic [LO_W+HI_W-1:0] sys_addr_o,
    input logic                 sys_data_oe,
    input logic                 mem_rd_n,
    input logic                 mem_wr_n,
    input logic                 io_rd_n,
    input logic                 io_wr_n,
    input logic                 cyc_halt,
    input logic                 cyc_write,
    input logic                 cyc_read,
    input logic                 cyc_fetch
);
    localparam int ADDR_W = LO_W + HI_W;

    assert_addr_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |=> sys_addr_o[LO_W-1:0] == $past(cpu_ad_i, 2));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ale) |=> $stable(sys_addr_o));

    assert_addr_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |=> sys_addr_o[ADDR_W-1:LO_W] == $past(hi_addr_i, 2));

    assert_mem_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_m && !rd_n && !hlda && status != 2'b00) |=> !mem_rd_n);

    assert_io_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_m && !wr_n && !hlda && status != 2'b00) |=> !io_wr_n);

    assert_float_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda || status == 2'b00) |=> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

    assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cyc_halt, cyc_write, cyc_read, cyc_fetch}));

    assert_fetch_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11) |=> cyc_fetch);

    assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ad_oe && sys_data_oe));

    assert_no_drive_after_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!cpu_ad_oe && !sys_data_oe));
endmodule

bind mbus_demux mbus_demux_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ale         (ale),
    .cpu_ad_i    (cpu_ad_i),
    .cpu_ad_oe   (cpu_ad_oe),
    .hi_addr_i   (hi_addr_i),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .io_m        (io_m),
    .status      (status),
    .hlda        (hlda),
    .sys_addr_o  (sys_addr_o),
    .sys_data_oe (sys_data_oe),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .io_rd_n     (io_rd_n),
    .io_wr_n     (io_wr_n),
    .cyc_halt    (cyc_halt),
    .cyc_write   (cyc_write),
    .cyc_read    (cyc_read),
    .cyc_fetch   (cyc_fetch)
);

// File: tb/mbus_demux_tb.sv
module mbus_demux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  cpu_ad_i = 8'h00;
    logic [7:0]  hi_addr_i = 8'h00;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        io_m = 1'b0;
    logic [1:0]  status = 2'b11;
    logic        hlda = 1'b0;
    logic [7:0]  sys_data_i = 8'h00;
    logic [7:0]  cpu_ad_o, sys_data_o;
    logic        cpu_ad_oe, sys_data_oe;
    logic [15:0] sys_addr_o;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic        cyc_halt, cyc_write, cyc_read, cyc_fetch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit seen_edge = 1'b0;

    always #10 clk = ~clk;

    mbus_demux u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cpu_ad_i(cpu_ad_i), .cpu_ad_o(cpu_ad_o),
        .cpu_ad_oe(cpu_ad_oe), .hi_addr_i(hi_addr_i), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .status(status), .hlda(hlda), .sys_addr_o(sys_addr_o),
        .sys_data_i(sys_data_i), .sys_data_o(sys_data_o), .sys_data_oe(sys_data_oe),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .cyc_halt(cyc_halt), .cyc_write(cyc_write), .cyc_read(cyc_read), .cyc_fetch(cyc_fetch)
    );

    // Behavioural reference, advanced on every rising edge
    bit         p_ale = 1'b0;
    bit [7:0]   p_ad, p_hi;
    bit [15:0]  m_addr;
    bit         m_cap;
    bit [3:0]   m_stb;      // mem_rd_n, mem_wr_n, io_rd_n, io_wr_n
    bit [3:0]   m_flags;    // halt, write, read, fetch
    bit [7:0]   m_cpu_o, m_sys_o;
    bit         m_cpu_oe, m_sys_oe;
    bit         m_float, m_in_rst;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        m_in_rst = !rst_n;
        m_float  = hlda || (status == 2'b00);
        m_cap    = 1'b0;
        if (!rst_n) begin
            m_addr = 16'h0; m_stb = 4'hF; m_flags = 4'h0;
            m_cpu_o = 8'h0; m_sys_o = 8'h0; m_cpu_oe = 1'b0; m_sys_oe = 1'b0;
        end else begin
            if (p_ale && !ale) begin
                m_addr = {p_hi, p_ad};
                m_cap  = 1'b1;
            end
            m_stb[3] = !(!m_float && !io_m && !rd_n);
            m_stb[2] = !(!m_float && !io_m && !wr_n);
            m_stb[1] = !(!m_float &&  io_m && !rd_n);
            m_stb[0] = !(!m_float &&  io_m && !wr_n);
            m_flags  = 4'b1000 >> status;
            m_cpu_oe = !ale && !m_float && !rd_n && wr_n;
            m_sys_oe = !ale && !m_float && !wr_n && rd_n;
            if (m_cpu_oe) m_cpu_o = sys_data_i;
            if (m_sys_oe) m_sys_o = cpu_ad_i;
        end
        p_ale = ale;
        p_ad  = cpu_ad_i;
        p_hi  = hi_addr_i;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output away from the rising edge
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            if (m_in_rst) begin
                chk("R10 reset addr", 32'(sys_addr_o), 32'(m_addr));
                chk("R10 reset strobes", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'(m_stb));
                chk("R10 reset flags", 32'({cyc_halt, cyc_write, cyc_read, cyc_fetch}), 32'(m_flags));
                chk("R10 reset data", 32'({cpu_ad_oe, sys_data_oe, cpu_ad_o, sys_data_o}), 32'h0);
            end else begin
                chk(m_cap ? "R1 low address capture" : "R2 low address hold",
                    32'(sys_addr_o[7:0]), 32'(m_addr[7:0]));
                chk("R3 high address", 32'(sys_addr_o[15:8]), 32'(m_addr[15:8]));
                chk(m_float ? "R5 floating strobes" : "R4 strobe decode",
                    32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'(m_stb));
                chk("R6 cycle flags", 32'({cyc_halt, cyc_write, cyc_read, cyc_fetch}), 32'(m_flags));
                chk("R7 read steer", 32'({cpu_ad_oe, cpu_ad_o}), 32'({m_cpu_oe, m_cpu_o}));
                chk("R8 write steer", 32'({sys_data_oe, sys_data_o}), 32'({m_sys_oe, m_sys_o}));
                chk("R9 enables exclusive", 32'(cpu_ad_oe && sys_data_oe), 32'h0);
            end
        end
    end

    // One machine cycle: address phase, data phase with optional waits, then strobe release
    task automatic bus_cycle(input logic [1:0] st, input logic iom, input logic rd,
                             input logic wr, input logic [15:0] a, input logic [7:0] d,
                             input int waits);
        @(negedge clk);
        ale = 1'b1; cpu_ad_i = a[7:0]; hi_addr_i = a[15:8];
        status = st; io_m = iom; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ale = 1'b0; rd_n = !rd; wr_n = !wr; sys_data_i = d;
        cpu_ad_i = wr ? d : ~a[7:0];
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            // R2: shared lines and high byte wander during wait states
            if (!wr) cpu_ad_i = cpu_ad_i ^ 8'h5A;
            hi_addr_i = hi_addr_i ^ 8'h3C;
            sys_data_i = sys_data_i + 8'h11;
        end
        @(negedge clk);
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; cpu_ad_i = 8'hEE;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R3 R4 R6 R7: memory read and opcode fetch
        bus_cycle(2'b11, 1'b0, 1'b1, 1'b0, 16'h12A5, 8'h3C, 0);
        bus_cycle(2'b10, 1'b0, 1'b1, 1'b0, 16'hFF00, 8'h81, 2);
        // R4 R8: memory write, then I/O write and I/O read
        bus_cycle(2'b01, 1'b0, 1'b0, 1'b1, 16'h8001, 8'hC7, 1);
        bus_cycle(2'b01, 1'b1, 1'b0, 1'b1, 16'h4242, 8'h19, 0);
        bus_cycle(2'b10, 1'b1, 1'b1, 1'b0, 16'h00FF, 8'h6E, 3);
        // R5: read strobe low while the bus is granted away
        @(negedge clk);
        hlda = 1'b1; rd_n = 1'b0; io_m = 1'b0; status = 2'b10;
        repeat (3) @(negedge clk);
        hlda = 1'b0; rd_n = 1'b1;
        // R5: halt status with stray strobes
        bus_cycle(2'b00, 1'b0, 1'b1, 1'b0, 16'h7777, 8'h55, 1);
        bus_cycle(2'b00, 1'b1, 1'b0, 1'b1, 16'h1357, 8'hAA, 0);
        // R9: both strobes low together, and a strobe low during the address pulse
        bus_cycle(2'b10, 1'b0, 1'b1, 1'b1, 16'hBEEF, 8'h99, 0);
        @(negedge clk);
        ale = 1'b1; rd_n = 1'b0; cpu_ad_i = 8'h4D; hi_addr_i = 8'hD4;
        @(negedge clk);
        ale = 1'b0; rd_n = 1'b1;
        // R2: a long wait stretch after a fetch
        bus_cycle(2'b11, 1'b0, 1'b1, 1'b0, 16'hA55A, 8'h10, 6);
        // R10: reset again in mid cycle
        @(negedge clk);
        ale = 1'b1; cpu_ad_i = 8'h31;
        @(negedge clk);
        rst_n = 1'b0; ale = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_cycle(2'b01, 1'b0, 1'b0, 1'b1, 16'h0123, 8'h45, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule